// File: doc/BRIEF.md
# Logic, Shift and Flag Unit

This block is the execute-stage slice of a 32-bit integer core that handles bitwise logic, arithmetic right shifts and a conditional shift-and-set operation. A combinational datapath computes the result and the new condition flags from an operation select, two register operands, an immediate field, a 4-bit condition code and the current carry, overflow, sign and zero flags. A single register stage then captures the result, so every operation finishes in one clock.

Every operation has its own rule for the flags. The logic operations clear overflow and keep carry. The arithmetic shifts report the last bit shifted out as carry. The shift-and-set operation tests the current flags against the condition code and shifts the outcome into bit 0 of the destination, leaving every flag unchanged. The shifter can be built as a log-depth stage chain or as a single operator, chosen by a parameter.

Top module: `lsf_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `out_valid`, `result` and `flags_out` are all zero.
- R2: `out_valid` equals `in_valid` one clock earlier. When `in_valid` was low, `result` and `flags_out` keep their previous values.
- R3: Op code 0 (invert) produces `~src_a`. It clears OV, sets S to result bit 31, sets Z when the result is zero and copies CY from the input. The flag vectors are packed as bit 3 = CY, bit 2 = OV, bit 1 = S, bit 0 = Z.
- R4: Op code 1 (register OR) produces `src_b | src_a`, with the same flag rule as R3.
- R5: Op code 2 (immediate OR) produces `src_a | {16'b0, imm}`, with the same flag rule as R3. The immediate is zero-extended.
- R6: Op code 3 (register shift) shifts `src_b` arithmetically right by `src_a[4:0]`. Bits 31:5 of `src_a` have no effect.
- R7: Op code 4 (immediate shift) shifts `src_b` arithmetically right by `imm[4:0]`. Bits 15:5 of `imm` have no effect.
- R8: For op codes 3 and 4, CY is the last bit shifted out, or 0 when the amount is zero. OV is cleared, and S and Z follow the result.
- R9: Op code 5 (shift-and-set) passes `flags_in` to `flags_out` unchanged.
- R10: Op code 5 produces `{src_b[30:0], hit}`. The condition `cc[2:0]` selects a base test: 0 = OV, 1 = CY, 2 = Z, 3 = CY|Z, 4 = S, 5 = always, 6 = S^OV, 7 = (S^OV)|Z. `hit` is that base test XOR `cc[3]`.
- R11: Op codes 6 and 7 produce `src_b` and leave all flags as given by `flags_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| op_sel | input | 3 | Operation select (R3–R11 codes) |
| src_a | input | 32 | First source register / shift amount register |
| src_b | input | 32 | Second source / destination old value |
| imm | input | 16 | Immediate field |
| cc | input | 4 | Condition code for shift-and-set |
| flags_in | input | 4 | Current flags {CY, OV, S, Z} |
| out_valid | output | 1 | Registered result valid |
| result | output | 32 | Registered result |
| flags_out | output | 4 | Registered updated flags {CY, OV, S, Z} |

## Verification
The hardest cases to reach are combinations in the flag and shift logic. One is a compound condition such as (S^OV)|Z, with and without inversion, tested against every flag pattern. The other is a shift amount taken from a register whose upper bits are set. The stimulus sweeps all 16 condition codes against all 16 input flag patterns. It also issues shifts at amounts 0, 1 and 31 from registers with garbage in bits 31:5. A long random phase with idle gaps then checks that results hold between operations.

// File: rtl/lsf_pkg.sv
package lsf_pkg;

   typedef enum logic [2:0] {
      OP_INV   = 3'd0,
      OP_ORR   = 3'd1,
      OP_ORI   = 3'd2,
      OP_SARR  = 3'd3,
      OP_SARI  = 3'd4,
      OP_SHSET = 3'd5,
      OP_RSV6  = 3'd6,
      OP_RSV7  = 3'd7
   } lsf_op_e;

   typedef struct packed {
      logic cy;
      logic ov;
      logic s;
      logic z;
   } lsf_flags_t;

   localparam int unsigned FLAG_W = 4;

endpackage

// File: rtl/lsf_cond.sv
module lsf_cond
   import lsf_pkg::*;
(
   input  lsf_flags_t fl,
   input  logic [3:0] cc,
   output logic       hit
);

   logic base;

   always_comb begin
      unique case (cc[2:0])
         3'd0: base = fl.ov;
         3'd1: base = fl.cy;
         3'd2: base = fl.z;
         3'd3: base = fl.cy | fl.z;
         3'd4: base = fl.s;
         3'd5: base = 1'b1;
         3'd6: base = fl.s ^ fl.ov;
         default: base = (fl.s ^ fl.ov) | fl.z;
      endcase
      hit = base ^ cc[3];
   end

endmodule

// File: rtl/lsf_logic.sv
module lsf_logic
   import lsf_pkg::*;
#(
   parameter int unsigned XLEN  = 32,
   parameter int unsigned IMM_W = 16
)(
   input  lsf_op_e          op,
   input  logic [XLEN-1:0]  a,
   input  logic [XLEN-1:0]  b,
   input  logic [IMM_W-1:0] imm,
   output logic [XLEN-1:0]  res
);

   localparam int unsigned PAD_W = XLEN - IMM_W;

   logic [XLEN-1:0] imm_x;

   generate
      if (PAD_W == 0) begin : g_nopad
         assign imm_x = imm;
      end else begin : g_pad
         assign imm_x = {{PAD_W{1'b0}}, imm};
      end
   endgenerate

   always_comb begin
      unique case (op)
         OP_INV:  res = ~a;
         OP_ORR:  res = b | a;
         OP_ORI:  res = a | imm_x;
         default: res = b;
      endcase
   end

endmodule

// File: rtl/lsf_sar.sv
module lsf_sar #(
   parameter int unsigned XLEN  = 32,
   parameter int unsigned STYLE = 0,
   localparam int unsigned SH_W = $clog2(XLEN)
)(
   input  logic [XLEN-1:0] val,
   input  logic [SH_W-1:0] amt,
   output logic [XLEN-1:0] res,
   output logic            cout
);

   // Operand carries one guard bit below the LSB; after the shift the
   // guard holds the last bit shifted out (zero for a zero amount).
   logic signed [XLEN:0] ext_out;

   generate
      if (STYLE == 0) begin : g_stages
         logic signed [XLEN:0] stg [0:SH_W];
         assign stg[0] = {val, 1'b0};
         for (genvar k = 0; k < SH_W; k++) begin : g_st
            assign stg[k+1] = amt[k] ? (stg[k] >>> (2 ** k)) : stg[k];
         end
         assign ext_out = stg[SH_W];
      end else begin : g_op
         logic signed [XLEN:0] ext_in;
         assign ext_in  = {val, 1'b0};
         assign ext_out = ext_in >>> amt;
      end
   endgenerate

   assign res  = ext_out[XLEN:1];
   assign cout = ext_out[0];

endmodule

// File: rtl/lsf_unit.sv
module lsf_unit
   import lsf_pkg::*;
#(
   parameter int unsigned XLEN      = 32,
   parameter int unsigned IMM_W     = 16,
   parameter int unsigned SAR_STYLE = 0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [2:0]        op_sel,
   input  logic [XLEN-1:0]   src_a,
   input  logic [XLEN-1:0]   src_b,
   input  logic [IMM_W-1:0]  imm,
   input  logic [3:0]        cc,
   input  logic [FLAG_W-1:0] flags_in,
   output logic              out_valid,
   output logic [XLEN-1:0]   result,
   output logic [FLAG_W-1:0] flags_out
);

   localparam int unsigned SH_W = $clog2(XLEN);

   generate
      if ((1 << SH_W) != XLEN || XLEN < 8) begin : g_bad_xlen
         $error("lsf_unit: XLEN must be a power of two of at least 8");
      end
      if (IMM_W < SH_W || IMM_W > XLEN) begin : g_bad_imm
         $error("lsf_unit: IMM_W must lie between log2(XLEN) and XLEN");
      end
      if (SAR_STYLE > 1) begin : g_bad_style
         $error("lsf_unit: SAR_STYLE must be 0 or 1");
      end
   endgenerate

   lsf_op_e    op;
   lsf_flags_t fin, fnew;
   assign op  = lsf_op_e'(op_sel);
   assign fin = lsf_flags_t'(flags_in);

   logic [XLEN-1:0] logic_res, sar_res, nxt_res;
   logic [SH_W-1:0] sh_amt;
   logic            sar_cy, cond_hit;

   assign sh_amt = (op == OP_SARI) ? imm[SH_W-1:0] : src_a[SH_W-1:0];

   lsf_logic #(.XLEN(XLEN), .IMM_W(IMM_W)) u_logic (
      .op(op), .a(src_a), .b(src_b), .imm(imm), .res(logic_res)
   );

   lsf_sar #(.XLEN(XLEN), .STYLE(SAR_STYLE)) u_sar (
      .val(src_b), .amt(sh_amt), .res(sar_res), .cout(sar_cy)
   );

   lsf_cond u_cond (.fl(fin), .cc(cc), .hit(cond_hit));

   always_comb begin
      nxt_res = logic_res;
      fnew    = fin;
      unique case (op)
         OP_INV, OP_ORR, OP_ORI: begin
            nxt_res = logic_res;
            fnew.ov = 1'b0;
            fnew.s  = logic_res[XLEN-1];
            fnew.z  = (logic_res == '0);
         end
         OP_SARR, OP_SARI: begin
            nxt_res = sar_res;
            fnew.cy = sar_cy;
            fnew.ov = 1'b0;
            fnew.s  = sar_res[XLEN-1];
            fnew.z  = (sar_res == '0);
         end
         OP_SHSET: begin
            nxt_res = {src_b[XLEN-2:0], cond_hit};
         end
         default: begin
            nxt_res = logic_res;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
         flags_out <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            result    <= nxt_res;
            flags_out <= fnew;
         end
      end
   end

endmodule

// File: rtl/lsf_unit_chk.sv
module lsf_unit_chk #(
   parameter int unsigned XLEN  = 32,
   parameter int unsigned IMM_W = 16
)(
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [2:0]        op_sel,
   input logic [XLEN-1:0]   src_a,
   input logic [XLEN-1:0]   src_b,
   input logic [3:0]        flags_in,
   input logic              out_valid,
   input logic [XLEN-1:0]   result,
   input logic [3:0]        flags_out
);

   // R1
   reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!out_valid && result == '0 && flags_out == '0));

   // R2
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(result) && $stable(flags_out)));

   // R3
   invert_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel == 3'd0) |=> (result == ~$past(src_a)));

   // R8
   shift_ov_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (op_sel == 3'd3 || op_sel == 3'd4)) |=> !flags_out[2]);

   // R9
   shset_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel == 3'd5) |=> (flags_out == $past(flags_in)));

   // R10
   shset_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel == 3'd5) |=> (result[XLEN-1:1] == $past(src_b[XLEN-2:0])));

   // R11
   reserved_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel[2:1] == 2'b11) |=> (result == $past(src_b) && flags_out == $past(flags_in)));

endmodule

bind lsf_unit lsf_unit_chk #(.XLEN(XLEN), .IMM_W(IMM_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
   .src_a(src_a), .src_b(src_b), .flags_in(flags_in),
   .out_valid(out_valid), .result(result), .flags_out(flags_out)
);

// File: tb/lsf_unit_test.sv
module lsf_unit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [2:0]  op_sel = '0;
   logic [31:0] src_a = '0, src_b = '0;
   logic [15:0] imm = '0;
   logic [3:0]  cc = '0, flags_in = '0;
   logic        out_valid;
   logic [31:0] result;
   logic [3:0]  flags_out;

   always #2 clk = ~clk;

   lsf_unit uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
      .src_a(src_a), .src_b(src_b), .imm(imm), .cc(cc), .flags_in(flags_in),
      .out_valid(out_valid), .result(result), .flags_out(flags_out)
   );

   int total = 0, bad = 0;
   bit finished = 1'b0;

   bit          e_valid = 0;
   bit [31:0]   e_res = 0;
   bit [3:0]    e_flg = 0;
   string       e_rtag = "R1", e_ftag = "R1";

   task automatic check(string tag, longint got, longint exp);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // flags vector: [3]=CY [2]=OV [1]=S [0]=Z
   function automatic bit cond_true(bit [3:0] code, bit [3:0] f);
      bit c = f[3], v = f[2], n = f[1], zz = f[0];
      case (code)
         4'h0: return v;          4'h8: return !v;
         4'h1: return c;          4'h9: return !c;
         4'h2: return zz;         4'hA: return !zz;
         4'h3: return c || zz;    4'hB: return !(c || zz);
         4'h4: return n;          4'hC: return !n;
         4'h5: return 1;          4'hD: return 0;
         4'h6: return n != v;     4'hE: return n == v;
         4'h7: return (n != v) || zz;
         default: return !((n != v) || zz);
      endcase
   endfunction

   task automatic model(bit v, bit [2:0] op, bit [31:0] a, bit [31:0] b,
                        bit [15:0] im, bit [3:0] code, bit [3:0] f);
      bit [31:0] r;
      bit        c;
      int        n;
      e_valid = v;
      if (!v) begin
         e_rtag = "R2"; e_ftag = "R2";
         return;
      end
      e_flg = f;
      case (op)
         0, 1, 2: begin
            r = (op == 0) ? ~a : (op == 1) ? (a | b) : (a | {16'h0, im});
            e_rtag = (op == 0) ? "R3" : (op == 1) ? "R4" : "R5";
            e_ftag = e_rtag;
            e_flg  = {f[3], 1'b0, r[31], r == 0};
         end
         3, 4: begin
            n = (op == 3) ? (a % 32) : (im % 32);
            r = b; c = 0;
            for (int i = 0; i < n; i++) begin
               c = r[0];
               r = {r[31], r[31:1]};
            end
            e_rtag = (op == 3) ? "R6" : "R7";
            e_ftag = "R8";
            e_flg  = {c, 1'b0, r[31], r == 0};
         end
         5: begin
            r = (b << 1) + (cond_true(code, f) ? 1 : 0);
            e_rtag = "R10"; e_ftag = "R9";
         end
         default: begin
            r = b; e_rtag = "R11"; e_ftag = "R11";
         end
      endcase
      e_res = r;
   endtask

   task automatic step(bit v, bit [2:0] op, bit [31:0] a, bit [31:0] b,
                       bit [15:0] im, bit [3:0] code, bit [3:0] f);
      @(negedge clk);
      check("R2", out_valid, e_valid);
      check(e_rtag, result, e_res);
      check(e_ftag, flags_out, e_flg);
      in_valid = v; op_sel = op; src_a = a; src_b = b;
      imm = im; cc = code; flags_in = f;
      model(v, op, a, b, im, code, f);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset values
      check("R1", out_valid, 0);
      check("R1", result, 0);
      check("R1", flags_out, 0);
      rst_n = 1'b1;
      // R3 invert: all ones gives zero, CY kept
      step(1, 0, 32'hFFFF_FFFF, 0, 0, 0, 4'b1110);
      step(1, 0, 32'h0000_1234, 0, 0, 0, 4'b0100);
      // R4 register OR
      step(1, 1, 32'h8000_0000, 32'h0000_0001, 0, 0, 4'b0111);
      step(1, 1, 0, 0, 0, 0, 4'b1000);
      // R5 immediate OR, zero extension
      step(1, 2, 32'h0000_0000, 32'hFFFF_FFFF, 16'h8001, 0, 4'b0110);
      step(1, 2, 32'h8000_0000, 0, 16'hFFFF, 0, 4'b1001);
      // R6 / R8 register shift, upper amount bits ignored
      step(1, 3, 32'hFFFF_FFE0, 32'h8000_0001, 0, 0, 4'b1111);
      step(1, 3, 32'h0000_0001, 32'h8000_0001, 0, 0, 4'b0000);
      step(1, 3, 32'hABCD_EF1F, 32'h7FFF_FFFF, 0, 0, 4'b0000);
      step(1, 3, 32'h0000_001F, 32'h8000_0000, 0, 0, 4'b0000);
      // R7 / R8 immediate shift, upper immediate bits ignored
      step(1, 4, 0, 32'hF000_0008, 16'hFFE4, 0, 4'b0100);
      step(1, 4, 0, 32'h0000_0010, 16'h0020, 0, 4'b1000);
      // idle cycles: R2 hold
      step(0, 2, 32'h1234_5678, 0, 16'hFFFF, 0, 0);
      step(0, 0, 0, 0, 0, 0, 0);
      // R9 / R10 full condition sweep
      for (int code = 0; code < 16; code++)
         for (int f = 0; f < 16; f++)
            step(1, 5, 0, 32'hC000_0003 ^ (code << 8), 0, code[3:0], f[3:0]);
      // R11 reserved codes
      step(1, 6, 32'h1111_1111, 32'h89AB_CDEF, 16'hFFFF, 4'h5, 4'b1010);
      step(1, 7, 0, 32'h0000_0000, 0, 4'h5, 4'b0101);
      // random mix with idle gaps
      for (int i = 0; i < 3000; i++)
         step(($urandom % 5) != 0, 3'($urandom), $urandom, $urandom,
              16'($urandom), 4'($urandom), 4'($urandom));
      step(0, 0, 0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0, 0, 0);
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: got running expected finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule